// File: doc/BRIEF.md
# Programmable GPIO Input Glitch Filter

This block conditions one asynchronous general-purpose input before the rest of the chip uses it. The raw pin is first brought into the clock domain by a short flop chain. An optional polarity flip is then applied with an XOR. A qualifier drives the filtered level, and that level moves to a new value only after the conditioned input has disagreed with it for a programmed number of clocks. Two 4-bit fields from the pin's configuration word set the filter time, and the same rules apply whether the pin is used as an input or an output. The count field is bits [7:4] of that word and the prescaler exponent is bits [11:8]. The filter time in clocks is (count + 1) × 2^select. At a 2.5 ns reference clock, select 4 with count 9 gives the default of about 400 ns. The longest setting, select 15 with count 15, is about 1.3 ms.

The qualifier is a three-state machine. PRIME is entered at reset and holds the output low while the synchroniser fills. HOLD means the conditioned input matches the output. QUAL means a disagreement is being timed. The transitions are:
- PRIME→HOLD (`load`): once SYNC_STAGES clocks have passed, the first real sample is copied straight to the output.
- HOLD→QUAL (`start`): the input disagrees and the full time has not yet been reached.
- QUAL→QUAL (`run`): the disagreement continues and the prescaler and tick counters advance.
- QUAL→HOLD or HOLD→HOLD with a flip (`accept`): the last qualifying clock is reached and the output takes the new level.
- QUAL→HOLD (`abandon`): the input returns to the output level and both counters clear.

Top module: `gpio_glitch_filter`

## Requirements
- R1: While reset is asserted, and on the first SYNC_STAGES clock edges after its release, `pin_filt` is 0.
- R2: On clock edge SYNC_STAGES+1 after reset release, `pin_filt` takes the raw level sampled on edge 1 XOR `pol_inv`, whatever its old value, so no false edge is reported.
- R3: After priming, the effective level is the raw pin delayed by SYNC_STAGES edges, XOR `pol_inv`. `pin_filt` changes to this level on the edge where the level has differed from `pin_filt` on T = (`flt_cnt`+1)·2^`flt_sel` consecutive edges, and never earlier.
- R4: Any edge on which the effective level equals `pin_filt` resets the count, so two disagreements of T−1 edges separated by one agreeing edge leave the output unchanged.
- R5: With `flt_sel` = 0 and `flt_cnt` = 0 (T = 1), `pin_filt` follows the raw pin 3 edges later, toggling on every clock if the pin does.
- R6: The inversion is applied before filtering. Setting `pol_inv` from 0 to 1 with a steady pin flips `pin_filt` exactly T edges later.
- R7: `flt_sel` = 4 with `flt_cnt` = 9 gives T = 160 clocks. A 159-clock pulse is removed and a 160-clock pulse passes.
- R8: At a large select (`flt_sel` = 10, `flt_cnt` = 15, T = 16384), a 16383-clock pulse is removed and a 16384-clock pulse passes.
- R9: No pulse on the effective level that is shorter than T appears on `pin_filt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 1 | Asynchronous raw pin level |
| flt_sel | input | SEL_W (4) | Prescaler exponent, configuration bits [11:8] |
| flt_cnt | input | CNT_W (4) | Filter count, configuration bits [7:4] |
| pol_inv | input | 1 | Invert the pin level before filtering, configuration bit 1 |
| pin_filt | output | 1 | Filtered, conditioned level |

## Verification
The bench builds the block with its default parameters: SYNC_STAGES of 2 and 4-bit select and count fields. These give a 15-bit prescaler and filter times from 1 to 524288 clocks. The bench drives selects 0, 2, 4 and 10, which covers the single-clock pass-through, short windows where off-by-one pulses are cheap to probe, the default 160-clock window and a 16384-clock window where the prescaler carries across many bits. The largest select is only reachable by assertion, because its window is too long for a directed run.

// File: rtl/gf_pkg.sv
package gf_pkg;

    typedef enum logic [1:0] {
        GF_PRIME = 2'd0,
        GF_HOLD  = 2'd1,
        GF_QUAL  = 2'd2
    } gf_state_e;

endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gf_prescale.sv
module gf_prescale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             wrap_o,
    output logic             zero_o
);

    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W:0]   full_mask;
    logic [PRE_W-1:0] mask;

    always_comb begin
        one_sh    = (PRE_W+1)'(1) << sel_i;
        full_mask = one_sh - (PRE_W+1)'(1);
        mask      = full_mask[PRE_W-1:0];
    end

    assign wrap_o = (pre_q == mask);
    assign zero_o = (pre_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
        end else if (adv_i) begin
            pre_q <= wrap_o ? '0 : pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/gf_fsm.sv
module gf_fsm
    import gf_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wrap_i,
    input  logic             pre_zero_i,
    output logic             pre_clr_o,
    output logic             pre_adv_o,
    output logic             filt_o
);

    localparam int FILL_W = $clog2(STAGES + 1);

    gf_state_e         state_q, state_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic [CNT_W-1:0]  tick_q, tick_d;
    logic              filt_q, filt_d;
    logic              differ;
    logic              last_clk;

    assign differ   = (lvl_i != filt_q);
    assign last_clk = wrap_i && (tick_q == cnt_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GF_PRIME;
            fill_q  <= '0;
            tick_q  <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
            tick_q  <= tick_d;
            filt_q  <= filt_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        fill_d    = fill_q;
        tick_d    = tick_q;
        filt_d    = filt_q;
        pre_clr_o = 1'b0;
        pre_adv_o = 1'b0;
        unique case (state_q)
            GF_PRIME: begin
                pre_clr_o = 1'b1;
                tick_d    = '0;
                if (fill_q == FILL_W'(STAGES)) begin
                    filt_d  = lvl_i;
                    state_d = GF_HOLD;
                end else begin
                    fill_d = fill_q + FILL_W'(1);
                end
            end
            GF_HOLD, GF_QUAL: begin
                if (!differ) begin
                    pre_clr_o = 1'b1;
                    tick_d    = '0;
                    state_d   = GF_HOLD;
                end else if (last_clk) begin
                    pre_clr_o = 1'b1;
                    tick_d    = '0;
                    filt_d    = lvl_i;
                    state_d   = GF_HOLD;
                end else begin
                    pre_adv_o = 1'b1;
                    tick_d    = tick_q + CNT_W'(wrap_i);
                    state_d   = GF_QUAL;
                end
            end
            default: begin
                pre_clr_o = 1'b1;
                tick_d    = '0;
                state_d   = GF_PRIME;
            end
        endcase
    end

    assign filt_o = filt_q;

    // R1: output stays low while priming
    a_r1_prime_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GF_PRIME) |-> !filt_q);

    // R3: any change after priming follows a disagreement on the prior edge
    a_r3_flip_needs_differ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != GF_PRIME && !$stable(filt_q)) |->
        ($past(lvl_i) != $past(filt_q)));

    // R4: agreement restarts both counters
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GF_PRIME && lvl_i == filt_q) |=> (tick_q == '0 && pre_zero_i));

    // R5: a single-clock window accepts on the first disagreeing edge
    a_r5_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != GF_PRIME && wrap_i && cnt_i == '0 && differ) |=>
        (filt_q == $past(lvl_i)));

endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 4,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic [SEL_W-1:0] flt_sel,
    input  logic [CNT_W-1:0] flt_cnt,
    input  logic             pol_inv,
    output logic             pin_filt
);

    logic pin_sync;
    logic lvl_eff;
    logic pre_clr;
    logic pre_adv;
    logic pre_wrap;
    logic pre_zero;

    gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw),
        .q_o   (pin_sync)
    );

    assign lvl_eff = pin_sync ^ pol_inv;

    gf_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pre_clr),
        .adv_i  (pre_adv),
        .sel_i  (flt_sel),
        .wrap_o (pre_wrap),
        .zero_o (pre_zero)
    );

    gf_fsm #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl_eff),
        .cnt_i      (flt_cnt),
        .wrap_i     (pre_wrap),
        .pre_zero_i (pre_zero),
        .pre_clr_o  (pre_clr),
        .pre_adv_o  (pre_adv),
        .filt_o     (pin_filt)
    );

endmodule

// File: tb/gpio_glitch_filter_tb.sv
`timescale 1ns/1ps
module gpio_glitch_filter_tb;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0;
    logic [3:0] flt_sel = 4'd0;
    logic [3:0] flt_cnt = 4'd0;
    logic       pol_inv = 1'b0;
    logic       pin_filt;

    int    total = 0;
    int    bad = 0;
    int    edges = 0;
    int    run = 0;
    bit    exp_q = 1'b0;
    bit    rawq[$];
    string tag = "R1";
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    gpio_glitch_filter u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_raw),
        .flt_sel  (flt_sel),
        .flt_cnt  (flt_cnt),
        .pol_inv  (pol_inv),
        .pin_filt (pin_filt)
    );

    task automatic check(input bit act, input bit expv, input string req);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: pin_filt=%0b expected=%0b at edge %0d", req, act, expv, edges);
        end
    endtask

    // one clock edge: advance the behavioural model with the inputs the design saw
    task automatic step();
        bit s_old;
        bit lvl;
        int t_win;
        @(negedge clk);
        s_old = (rawq.size() >= SYNC) ? rawq[rawq.size()-SYNC] : 1'b0;
        rawq.push_back(pin_raw);
        if (rawq.size() > 4) void'(rawq.pop_front());
        edges++;
        lvl   = s_old ^ pol_inv;
        t_win = (int'(flt_cnt) + 1) << flt_sel;
        if (edges == SYNC + 1) begin
            exp_q = lvl;
            run   = 0;
        end else if (edges > SYNC + 1) begin
            if (lvl != exp_q) begin
                run++;
                if (run == t_win) begin
                    exp_q = lvl;
                    run   = 0;
                end
            end else begin
                run = 0;
            end
        end
        check(pin_filt, exp_q, tag);
    endtask

    task automatic hold(input bit v, input int n);
        pin_raw = v;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int tw;
        // R1: reset holds the output low
        pin_raw = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pin_filt, 1'b0, "R1");
        rst_n = 1'b1;
        tag = "R1";
        step();
        step();
        check(pin_filt, 1'b0, "R1");
        // R2: first sample loaded straight through
        tag = "R2";
        step();
        check(pin_filt, 1'b1, "R2");

        // R5: single-clock window, pin toggling every clock
        tag = "R5";
        hold(1'b0, 2);
        check(pin_filt, 1'b1, "R5");
        step();
        check(pin_filt, 1'b0, "R5");
        for (int k = 0; k < 12; k++) hold(k[0], 1);
        hold(1'b1, 6);
        check(pin_filt, 1'b1, "R5");

        // R3, R9: T = 8 window
        flt_sel = 4'd2; flt_cnt = 4'd1; tw = 8;
        tag = "R9";
        hold(1'b0, tw - 1);
        hold(1'b1, tw + 4);
        check(pin_filt, 1'b1, "R9");
        tag = "R3";
        hold(1'b0, tw);
        hold(1'b1, 2);
        check(pin_filt, 1'b0, "R3");
        hold(1'b1, tw + 4);
        check(pin_filt, 1'b1, "R3");

        // R4: restart on agreement
        tag = "R4";
        hold(1'b0, tw - 1);
        hold(1'b1, 1);
        hold(1'b0, tw - 1);
        hold(1'b1, tw + 4);
        check(pin_filt, 1'b1, "R4");

        // R6: inversion before the filter
        tag = "R6";
        pin_raw = 1'b1;
        pol_inv = 1'b1;
        for (int i = 0; i < tw - 1; i++) step();
        check(pin_filt, 1'b1, "R6");
        step();
        check(pin_filt, 1'b0, "R6");
        hold(1'b0, tw + 4);
        check(pin_filt, 1'b1, "R6");
        pol_inv = 1'b0;
        hold(1'b0, tw + 4);
        check(pin_filt, 1'b0, "R6");

        // R7: default window of 160 clocks
        flt_sel = 4'd4; flt_cnt = 4'd9; tw = 160;
        tag = "R7";
        hold(1'b1, tw - 1);
        hold(1'b0, tw + 4);
        check(pin_filt, 1'b0, "R7");
        hold(1'b1, tw);
        hold(1'b0, 2);
        check(pin_filt, 1'b1, "R7");
        hold(1'b0, tw + 4);
        check(pin_filt, 1'b0, "R7");

        // R8: large prescaler
        flt_sel = 4'd10; flt_cnt = 4'd15; tw = 16384;
        tag = "R8";
        hold(1'b1, tw - 1);
        hold(1'b0, 4);
        check(pin_filt, 1'b0, "R8");
        hold(1'b1, tw);
        hold(1'b0, 2);
        check(pin_filt, 1'b1, "R8");
        hold(1'b0, tw + 4);
        check(pin_filt, 1'b0, "R8");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule